// File: doc/BRIEF.md
# Conditional execution flag evaluator

This block decides, for every instruction a processor issues, whether that instruction is allowed to take effect, and it owns the four status flags that the decision is based on: negative, zero, carry and overflow. Each instruction arrives with a 4-bit condition field, a valid strobe and a flag-set bit. The condition field is tested against the flags as they stand. The result is registered and appears on the execute-enable output one cycle later.

When a valid instruction passes its condition and has its flag-set bit high, the flag register is reloaded on that same clock edge. The zero and negative flags are derived from the ALU result bus. The carry and overflow flags are taken directly from the ALU's carry-out and overflow outputs.

A compare is issued as a subtraction with the flag-set bit high, and its numeric result is simply not stored anywhere. An instruction that fails its condition is suppressed entirely: execute-enable stays low and the flags keep their old value, even when its flag-set bit is high. The ALU, branch target computation and pipeline flushing sit outside this block.

Top module: `cond_exec_unit`

## Requirements
- R1: While reset is asserted and after it is released, flags_o reads 4'b0000 and exec_en_o reads 0.
- R2: Condition codes 4'b1110 and 4'b1111 always pass. A valid instruction carrying either code raises exec_en_o after the next clock edge, whatever the flags are.
- R3: Code 4'b0000 passes when Z is 1, and code 4'b0001 passes when Z is 0.
- R4: Each of the following codes tests one flag:
  - 4'b0010 passes when C is 1, and 4'b0011 passes when C is 0.
  - 4'b0100 passes when N is 1, and 4'b0101 passes when N is 0.
  - 4'b0110 passes when V is 1, and 4'b0111 passes when V is 0.
- R5: Code 4'b1000 passes when C is 1 and Z is 0. Code 4'b1001 passes when C is 0 or Z is 1.
- R6: The signed comparisons are:
  - 4'b1010 passes when N equals V, and 4'b1011 passes when N differs from V.
  - 4'b1100 passes when Z is 0 and N equals V.
  - 4'b1101 passes when Z is 1 or N differs from V.
- R7: exec_en_o is registered. It is 1 in the cycle after a valid instruction whose condition passes, and 0 after an invalid cycle or a failing condition.
- R8: A valid, passing instruction with set_flags_i high loads flags_o = {N,Z,C,V} (bit 3 down to bit 0) on that clock edge:
  - N is the MSB of alu_result_i.
  - Z is 1 when alu_result_i is all zeros.
  - C is alu_carry_i.
  - V is alu_ovf_i.
- R9: An instruction with set_flags_i low leaves flags_o unchanged, even when it executes.
- R10: An instruction whose condition fails leaves flags_o unchanged, even with set_flags_i high.
- R11: A cycle with in_valid_i low changes neither flags_o nor exec_en_o, which is 0 afterwards, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | An instruction is presented this cycle |
| cond_i | input | 4 | Condition field of the instruction |
| set_flags_i | input | 1 | Instruction wants to update the flags |
| alu_result_i | input | DATA_W | ALU result of the instruction |
| alu_carry_i | input | 1 | ALU carry-out |
| alu_ovf_i | input | 1 | ALU signed overflow |
| exec_en_o | output | 1 | Registered execute enable for the previous instruction |
| flags_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
Some properties are checked on every cycle by assertions:
- An idle strobe or a clear flag-set bit keeps the flags stable.
- A low execute-enable never comes with a flag change.
- The two unconditional codes always execute.
- Execute-enable only ever follows a valid cycle.
- The zero and carry flags track the ALU inputs after an unconditional flag-setting instruction.

The exact pass/fail truth table for all sixteen codes is covered only by the bench. It drives every reachable flag combination and checks each code against an independently computed table, including flag-setting instructions whose condition fails. The N=1 with Z=1 state cannot be loaded from a real result, so it stays outside the sweep.

// File: rtl/cond_pkg.sv
package cond_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Upper three bits of the condition field select a test group;
  // the low bit inverts the group test (except for the always group).
  typedef enum logic [2:0] {
    GRP_ZERO   = 3'd0,
    GRP_CARRY  = 3'd1,
    GRP_SIGN   = 3'd2,
    GRP_OVF    = 3'd3,
    GRP_UHIGH  = 3'd4,
    GRP_SGE    = 3'd5,
    GRP_SGT    = 3'd6,
    GRP_ALWAYS = 3'd7
  } cond_grp_e;

  localparam int unsigned COND_W  = 4;
  localparam int unsigned FLAGS_W = 4;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o
);

  cond_grp_e grp;
  logic      base;
  logic      sign_eq;

  assign grp     = cond_grp_e'(cond_i[COND_W-1:1]);
  assign sign_eq = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (grp)
      GRP_ZERO:   base = flags_i.z;
      GRP_CARRY:  base = flags_i.c;
      GRP_SIGN:   base = flags_i.n;
      GRP_OVF:    base = flags_i.v;
      GRP_UHIGH:  base = flags_i.c & ~flags_i.z;
      GRP_SGE:    base = sign_eq;
      GRP_SGT:    base = ~flags_i.z & sign_eq;
      default:    base = 1'b1;
    endcase
  end

  // Always group ignores the inversion bit (R2)
  assign pass_o = (grp == GRP_ALWAYS) ? 1'b1 : (base ^ cond_i[0]);

endmodule

// File: rtl/flag_calc.sv
module flag_calc
  import cond_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output flags_t            flags_o
);

  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    flags_o.n = result_i[MSB];
    flags_o.z = ~|result_i;
    flags_o.c = carry_i;
    flags_o.v = ovf_i;
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   load_i,
  input  flags_t next_i,
  output flags_t flags_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flags_o <= '0;
    end else if (load_i) begin
      flags_o <= next_i;
    end
  end

endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
  import cond_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              in_valid_i,
  input  logic [3:0]        cond_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] alu_result_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  output logic              exec_en_o,
  output logic [3:0]        flags_o
);

  flags_t cur_flags;
  flags_t new_flags;
  logic   pass;
  logic   fire;
  logic   commit;
  logic   exec_q;

  cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (cur_flags),
    .pass_o  (pass)
  );

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .result_i (alu_result_i),
    .carry_i  (alu_carry_i),
    .ovf_i    (alu_ovf_i),
    .flags_o  (new_flags)
  );

  assign fire   = in_valid_i & pass;
  assign commit = fire & set_flags_i;

  flag_store u_store (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (commit),
    .next_i  (new_flags),
    .flags_o (cur_flags)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      exec_q <= 1'b0;
    end else begin
      exec_q <= fire;
    end
  end

  assign exec_en_o = exec_q;
  assign flags_o   = cur_flags;

  // R2: unconditional codes always execute
  assert_always_exec_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && cond_i[3:1] == 3'b111) |=> exec_en_o);

  // R7: execute enable only follows a valid cycle
  assert_exec_origin_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    exec_en_o |-> $past(in_valid_i));

  // R8: zero and carry flags follow the ALU after an unconditional update
  assert_flag_load_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && set_flags_i && cond_i[3:1] == 3'b111) |=>
      (flags_o[2] == ($past(alu_result_i) == '0)) && (flags_o[1] == $past(alu_carry_i)));

  // R9: flag-set bit low keeps flags
  assert_no_set_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !set_flags_i |=> $stable(flags_o));

  // R10: a suppressed instruction never changes the flags
  assert_skip_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !exec_en_o |-> $stable(flags_o));

  // R11: idle cycle is quiet
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> (!exec_en_o && $stable(flags_o)));

endmodule

// File: tb/cond_exec_unit_tb.sv
`timescale 1ns/1ps
module cond_exec_unit_tb;

  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          vld;
  logic [3:0]    cc;
  logic          sf;
  logic [DW-1:0] res;
  logic          cy;
  logic          ov;
  logic          exec_en;
  logic [3:0]    flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cond_exec_unit #(.DATA_W(DW)) u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .in_valid_i   (vld),
    .cond_i       (cc),
    .set_flags_i  (sf),
    .alu_result_i (res),
    .alu_carry_i  (cy),
    .alu_ovf_i    (ov),
    .exec_en_o    (exec_en),
    .flags_o      (flags)
  );

  function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, k, v;
    {n, z, k, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return k;
      4'd3:  return !k;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return k && !z;
      4'd9:  return !k || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'd1) return "R3";
    if (c <= 4'd7) return "R4";
    if (c <= 4'd9) return "R5";
    if (c <= 4'd13) return "R6";
    return "R2";
  endfunction

  // ALU result that produces the N and Z bits of f
  function automatic logic [DW-1:0] res_for(input logic [3:0] f);
    if (f[2]) return '0;
    if (f[3]) return {1'b1, {(DW-1){1'b0}}} | DW'(5);
    return DW'(3);
  endfunction

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Present one cycle of inputs at a negedge, sample at the following negedge.
  task automatic issue(input logic v, input logic [3:0] c, input logic s,
                       input logic [DW-1:0] r, input logic k, input logic o);
    @(negedge clk);
    vld = v; cc = c; sf = s; res = r; cy = k; ov = o;
    @(negedge clk);
    vld = 1'b0; sf = 1'b0;
  endtask

  task automatic load_flags(input logic [3:0] f);
    issue(1'b1, 4'hE, 1'b1, res_for(f), f[1], f[0]);
    check("R8", "flag load", flags, f);
    check("R2", "code 1110 executes", {3'b0, exec_en}, 4'd1);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vld = 1'b0; cc = '0; sf = 1'b0; res = '0; cy = 1'b0; ov = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "flags in reset", flags, 4'b0000);
    check("R1", "exec in reset", {3'b0, exec_en}, 4'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "flags after reset", flags, 4'b0000);
    check("R1", "exec after reset", {3'b0, exec_en}, 4'd0);

    // code 1111 with flag set
    issue(1'b1, 4'hF, 1'b1, DW'(0), 1'b1, 1'b0);
    check("R2", "code 1111 executes", {3'b0, exec_en}, 4'd1);
    check("R8", "code 1111 loads", flags, 4'b0110);

    for (int fs = 0; fs < 16; fs++) begin
      logic [3:0] f = 4'(fs);
      if (f[3] && f[2]) continue;
      load_flags(f);
      for (int ci = 0; ci < 16; ci++) begin
        logic [3:0] c = 4'(ci);
        logic [3:0] tgt = f ^ 4'b0011;
        bit p = exp_pass(c, f);
        // flag-set bit low: exec per table, flags untouched
        issue(1'b1, c, 1'b0, ~res_for(f), ~f[1], ~f[0]);
        check(req_of(c), $sformatf("R7 exec code %b flags %b", c, f), {3'b0, exec_en}, {3'b0, p});
        check("R9", "no-set keeps flags", flags, f);
        // flag-set bit high: update only if passing
        issue(1'b1, c, 1'b1, res_for(tgt), tgt[1], tgt[0]);
        if (p) begin
          check("R8", $sformatf("set on pass code %b", c), flags, tgt);
          load_flags(f);
        end else begin
          check("R10", $sformatf("failed code %b keeps flags", c), flags, f);
          check("R7", "failed exec low", {3'b0, exec_en}, 4'd0);
        end
      end
      // invalid strobe with everything else set to act
      issue(1'b0, 4'hE, 1'b1, DW'(0), ~f[1], ~f[0]);
      check("R11", "idle keeps flags", flags, f);
      check("R11", "idle exec low", {3'b0, exec_en}, 4'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule